// File: doc/BRIEF.md
# Burst-Periodic Stimulus Event Generator

This block produces a timeline of stimulus events with two timing levels: a burst opens at the start of every period, and within the open burst window events recur at a programmed spacing. Between bursts the generator stays quiet, so a device under test sees intermittent activity rather than constant load. A 16-bit LFSR, seeded at start, varies each event's exact position within bounds and picks an event code. Every event appears as a one-cycle strobe with its code and a timestamp, so a downstream driver can turn it into pin toggles or packets at the right time.

Software-free control is a start pulse, a stop pulse and a run-length limit in cycles. The spacing, burst length, period, jitter mask, run length and seed are configuration inputs that are held stable while a run is active. The controller has three states. `ST_IDLE` leaves on an accepted start to `ST_BURST`, or to `ST_GAP` when the effective burst length is zero. `ST_BURST` goes to `ST_GAP` after its last event. Both `ST_BURST` and `ST_GAP` go to `ST_BURST` at the period wrap. Every active state returns to `ST_IDLE` on stop or when the run length is used up.

Top module: `burst_event_gen`

## Requirements
- R1: With a zero jitter mask, events fire at period positions 0, S, 2S, ... where S is `cfg_spacing`, while the position is inside the burst window.
- R2: No event fires at a period position greater than or equal to the effective burst length, which is `cfg_burst`, or `cfg_period` when `cfg_burst` is at least `cfg_period`.
- R3: The period position starts at 0 at start and wraps to 0 after `cfg_period` cycles, and each wrap reopens the burst with its first nominal event at position 0.
- R4: An event's position is its nominal position plus an offset. The offset's magnitude is LFSR bits [7:0] ANDed with `cfg_jitter_mask`, and it is negative when LFSR bit 15 is 1. The result is clamped to lie after the burst's previous event and no later than the last position of the burst window. After an event placed at that last position, the burst ends.
- R5: The LFSR loads `cfg_seed` on start, or 1 if the seed is zero. It shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It advances once per fired event. An event's code is LFSR bits [9:8], and the same LFSR value sets that event's jitter.
- R6: A run started with `cfg_run_len` = N stays active (`busy` high) for exactly N cycles. A start with N = 0 is ignored.
- R7: `evt_time` equals the number of cycles since the cycle in which the run began, starting at 0.
- R8: After reset `busy`, `evt_strobe` and `cfg_err` are low. A start pulse while idle begins a run in the next cycle. A stop pulse ends the run in the next cycle. A start pulse while a run is active has no effect.
- R9: On start, `cfg_err` is set when `cfg_burst` is at least `cfg_period`, and is cleared otherwise. It holds that value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (idle only) |
| stop | input | 1 | End the active run |
| cfg_spacing | input | 16 | Nominal cycles between events in a burst |
| cfg_burst | input | 16 | Burst window length in cycles |
| cfg_period | input | 16 | Period length in cycles |
| cfg_jitter_mask | input | 8 | Mask bounding jitter magnitude |
| cfg_run_len | input | 32 | Total run length in cycles |
| cfg_seed | input | 16 | LFSR seed |
| evt_strobe | output | 1 | One-cycle event pulse |
| evt_code | output | 2 | Event type |
| evt_time | output | 32 | Cycles since run start |
| busy | output | 1 | Run active |
| cfg_err | output | 1 | Burst length truncated to period |

## Verification
A run with no jitter and a burst shorter than the period has its event times checked against a plain formula. This separates an error in spacing from an error in window closing or period wrap. An oversized burst shows the truncation and the error flag. A jittered run with a known seed shows whether the offsets and clamping follow the LFSR, and whether events leave the nominal grid while staying in order and inside the window. A known seed with no jitter, and a zero seed, fix the code sequence. A run that is stopped early, with a start pulse issued while it is busy, shows that stop acts and that the extra start is ignored. A cycle-accurate behavioural model is compared on every clock in all runs.

// File: rtl/bev_pkg.sv
package bev_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } bev_state_e;
endpackage

// File: rtl/bev_lfsr.sv
module bev_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] seed,
    output logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic [W-1:0] st_q;

    assign cur = st_q;
    assign nxt = {st_q[W-2:0], ^(st_q & TAPS)};

    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= {{(W-1){1'b0}}, 1'b1};
        else if (load) st_q <= seed;
        else if (adv)  st_q <= nxt;
    end
endmodule

// File: rtl/bev_target.sv
module bev_target #(
    parameter int TW = 16,
    parameter int JW = 8,
    parameter int RW = 16
) (
    input  logic [TW-1:0] base,
    input  logic [RW-1:0] rnd,
    input  logic [JW-1:0] mask,
    input  logic [TW-1:0] lo,
    input  logic [TW-1:0] hi,
    output logic [TW-1:0] tgt
);
    localparam int SW = TW + 2;

    logic [JW-1:0]        mag;
    logic signed [SW-1:0] base_s, mag_s, raw_s, lo_s, hi_s;

    always_comb begin
        mag    = rnd[JW-1:0] & mask;
        base_s = $signed({2'b00, base});
        mag_s  = $signed({{(SW-JW){1'b0}}, mag});
        lo_s   = $signed({2'b00, lo});
        hi_s   = $signed({2'b00, hi});
        raw_s  = rnd[RW-1] ? (base_s - mag_s) : (base_s + mag_s);
        if (raw_s < lo_s)      tgt = lo;
        else if (raw_s > hi_s) tgt = hi;
        else                   tgt = raw_s[TW-1:0];
    end
endmodule

// File: rtl/burst_event_gen.sv
module burst_event_gen #(
    parameter int TW       = 16,
    parameter int CW       = 32,
    parameter int JW       = 8,
    parameter int RW       = 16,
    parameter int CODE_W   = 2,
    parameter int CODE_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [TW-1:0]     cfg_spacing,
    input  logic [TW-1:0]     cfg_burst,
    input  logic [TW-1:0]     cfg_period,
    input  logic [JW-1:0]     cfg_jitter_mask,
    input  logic [CW-1:0]     cfg_run_len,
    input  logic [RW-1:0]     cfg_seed,
    output logic              evt_strobe,
    output logic [CODE_W-1:0] evt_code,
    output logic [CW-1:0]     evt_time,
    output logic              busy,
    output logic              cfg_err
);
    import bev_pkg::*;

    localparam logic [TW-1:0] ONE_T = {{(TW-1){1'b0}}, 1'b1};

    bev_state_e    st_q, st_d;
    logic [TW-1:0] pos_q, nom_q, tgt_q;
    logic [CW-1:0] tick_q;
    logic          err_q;

    logic [TW-1:0] eff_burst, last_pos, tgt_in, tgt_new;
    logic [TW:0]   nom_sum;
    logic [RW-1:0] seed_nz, l_cur, l_nxt, rnd_new;
    logic          start_go, fire, wrap, run_end, more, trunc;

    // effective window
    assign trunc     = (cfg_burst >= cfg_period);
    assign eff_burst = trunc ? cfg_period : cfg_burst;
    assign last_pos  = eff_burst - ONE_T;
    assign seed_nz   = (cfg_seed == '0) ? {{(RW-1){1'b0}}, 1'b1} : cfg_seed;

    assign start_go = (st_q == ST_IDLE) && start && (cfg_run_len != '0);
    assign fire     = (st_q == ST_BURST) && (pos_q == tgt_q);
    assign wrap     = (pos_q == cfg_period - ONE_T);
    assign run_end  = (tick_q == cfg_run_len - 1'b1);
    assign nom_sum  = {1'b0, nom_q} + {1'b0, cfg_spacing};
    assign more     = (nom_sum < {1'b0, eff_burst}) && (tgt_q != last_pos);
    assign rnd_new  = start_go ? seed_nz : (fire ? l_nxt : l_cur);

    bev_lfsr #(.W(RW)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start_go),
        .adv  (fire),
        .seed (seed_nz),
        .cur  (l_cur),
        .nxt  (l_nxt)
    );

    // next event inside the current burst
    bev_target #(.TW(TW), .JW(JW), .RW(RW)) u_tgt_in (
        .base(nom_sum[TW-1:0]),
        .rnd (l_nxt),
        .mask(cfg_jitter_mask),
        .lo  (tgt_q + ONE_T),
        .hi  (last_pos),
        .tgt (tgt_in)
    );

    // first event of a fresh burst
    bev_target #(.TW(TW), .JW(JW), .RW(RW)) u_tgt_new (
        .base('0),
        .rnd (rnd_new),
        .mask(cfg_jitter_mask),
        .lo  ('0),
        .hi  (last_pos),
        .tgt (tgt_new)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_go) st_d = (eff_burst != '0) ? ST_BURST : ST_GAP;
            end
            ST_BURST: begin
                if (stop || run_end) st_d = ST_IDLE;
                else if (wrap)       st_d = ST_BURST;
                else if (fire && !more) st_d = ST_GAP;
            end
            ST_GAP: begin
                if (stop || run_end) st_d = ST_IDLE;
                else if (wrap)       st_d = (eff_burst != '0) ? ST_BURST : ST_GAP;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            nom_q  <= '0;
            tgt_q  <= '0;
            tick_q <= '0;
            err_q  <= 1'b0;
        end else if (start_go) begin
            pos_q  <= '0;
            nom_q  <= '0;
            tgt_q  <= tgt_new;
            tick_q <= '0;
            err_q  <= trunc;
        end else if (st_q != ST_IDLE) begin
            tick_q <= tick_q + 1'b1;
            if (wrap) begin
                pos_q <= '0;
                nom_q <= '0;
                tgt_q <= tgt_new;
            end else begin
                pos_q <= pos_q + ONE_T;
                if (fire && more) begin
                    nom_q <= nom_sum[TW-1:0];
                    tgt_q <= tgt_in;
                end
            end
        end
    end

    always_comb begin
        busy       = (st_q != ST_IDLE);
        evt_strobe = fire;
        evt_code   = l_cur[CODE_LSB +: CODE_W];
        evt_time   = tick_q;
        cfg_err    = err_q;
    end
endmodule

// File: rtl/bev_checker.sv
module bev_checker #(
    parameter int TW = 16,
    parameter int CW = 32,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt_strobe,
    input logic          busy,
    input logic          cfg_err,
    input logic [CW-1:0] evt_time,
    input logic [CW-1:0] cfg_run_len,
    input logic [TW-1:0] pos_q,
    input logic [TW-1:0] eff_burst,
    input logic [RW-1:0] l_cur
);
    AST_STROBE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |-> busy); // R8

    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |-> (pos_q < eff_burst)); // R2

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (evt_time == $past(evt_time) + 1'b1)); // R7

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (evt_time < cfg_run_len)); // R6

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (l_cur != '0)); // R5

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_err)); // R9
endmodule

bind burst_event_gen bev_checker #(.TW(TW), .CW(CW), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .busy       (busy),
    .cfg_err    (cfg_err),
    .evt_time   (evt_time),
    .cfg_run_len(cfg_run_len),
    .pos_q      (pos_q),
    .eff_burst  (eff_burst),
    .l_cur      (l_cur)
);

// File: tb/burst_event_gen_tb_top.sv
`timescale 1ns/1ps
module burst_event_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0;
    logic [15:0] cfg_spacing = 16'd1, cfg_burst = 16'd1, cfg_period = 16'd2;
    logic [7:0]  cfg_jitter_mask = 8'd0;
    logic [31:0] cfg_run_len = 32'd0;
    logic [15:0] cfg_seed = 16'd1;
    logic        evt_strobe, busy, cfg_err;
    logic [1:0]  evt_code;
    logic [31:0] evt_time;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // behavioural model state
    bit m_run = 0, m_burst = 0, m_err = 0;
    int m_pos, m_nom, m_tgt, m_tick, m_s;
    int ev_t[$];
    int ev_c[$];
    int busy_cnt;

    always #2 clk = ~clk;

    burst_event_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_spacing(cfg_spacing), .cfg_burst(cfg_burst), .cfg_period(cfg_period),
        .cfg_jitter_mask(cfg_jitter_mask), .cfg_run_len(cfg_run_len), .cfg_seed(cfg_seed),
        .evt_strobe(evt_strobe), .evt_code(evt_code), .evt_time(evt_time),
        .busy(busy), .cfg_err(cfg_err)
    );

    function automatic int lfsr_step(int s);
        int fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s << 1) & 16'hFFFF) | fb;
    endfunction

    function automatic int place(int base, int s, int lo, int hi);
        int m = (s & 255) & int'(cfg_jitter_mask);
        int r = ((s >> 15) & 1) ? base - m : base + m;
        if (r < lo) return lo;
        if (r > hi) return hi;
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare at negedge, then advance model with current inputs, then wait one cycle
    task automatic step();
        int eff = (cfg_burst >= cfg_period) ? int'(cfg_period) : int'(cfg_burst);
        bit m_fire = m_run && m_burst && (m_pos == m_tgt);
        check(busy == m_run, "R8 busy", busy, m_run);
        check(evt_strobe == m_fire, "R1 strobe", evt_strobe, m_fire);
        check(cfg_err == m_err, "R9 cfg_err", cfg_err, m_err);
        if (m_fire) begin
            check(int'(evt_code) == ((m_s >> 8) & 3), "R5 code", evt_code, (m_s >> 8) & 3);
            check(int'(evt_time) == m_tick, "R7 time", evt_time, m_tick);
        end
        if (busy) busy_cnt++;
        if (evt_strobe) begin ev_t.push_back(int'(evt_time)); ev_c.push_back(int'(evt_code)); end
        if (!m_run) begin
            if (start && cfg_run_len != 0) begin
                m_run = 1; m_tick = 0; m_pos = 0; m_nom = 0;
                m_s = (cfg_seed == 0) ? 1 : int'(cfg_seed);
                m_err = (cfg_burst >= cfg_period);
                m_burst = (eff > 0);
                m_tgt = place(0, m_s, 0, eff - 1);
            end
        end else if (stop || m_tick == int'(cfg_run_len) - 1) begin
            m_run = 0;
        end else begin
            int sa = m_fire ? lfsr_step(m_s) : m_s;
            if (m_pos == int'(cfg_period) - 1) begin
                m_pos = 0; m_nom = 0; m_burst = (eff > 0);
                m_tgt = place(0, sa, 0, eff - 1);
            end else begin
                m_pos++;
                if (m_fire) begin
                    int nn = m_nom + int'(cfg_spacing);
                    if (nn < eff && m_tgt != eff - 1) begin
                        m_nom = nn;
                        m_tgt = place(nn, sa, m_tgt + 1, eff - 1);
                    end else m_burst = 0;
                end
            end
            m_s = sa;
            m_tick++;
        end
        @(posedge clk); @(negedge clk);
    endtask

    task automatic run(int sp, int bl, int pr, int mk, int rl, int sd);
        cfg_spacing = 16'(sp); cfg_burst = 16'(bl); cfg_period = 16'(pr);
        cfg_jitter_mask = 8'(mk); cfg_run_len = 32'(rl); cfg_seed = 16'(sd);
        ev_t.delete(); ev_c.delete(); busy_cnt = 0;
        start = 1; step(); start = 0;
        for (int i = 0; i < rl + 2; i++) step();
    endtask

    // nominal grid check for zero-jitter runs: R1 R2 R3
    task automatic grid_check(int sp, int eff, int pr, int rl);
        int exp_t[$];
        for (int t = 0; t < rl; t++)
            if ((t % pr) < eff && ((t % pr) % sp) == 0) exp_t.push_back(t);
        check(ev_t.size() == exp_t.size(), "R1 R3 event count", ev_t.size(), exp_t.size());
        for (int i = 0; i < exp_t.size() && i < ev_t.size(); i++)
            check(ev_t[i] == exp_t[i], "R2 R3 event time", ev_t[i], exp_t[i]);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state R8 R9
        check(busy == 0, "R8 reset busy", busy, 0);
        check(evt_strobe == 0, "R8 reset strobe", evt_strobe, 0);
        check(cfg_err == 0, "R9 reset err", cfg_err, 0);

        // zero run length: start ignored R6
        cfg_run_len = 0; start = 1; step(); start = 0; step();
        check(busy == 0, "R6 zero length ignored", busy, 0);

        // plain grid, known seed codes R1 R2 R3 R5 R6
        run(4, 10, 16, 0, 40, 16'h0300);
        grid_check(4, 10, 16, 40);
        check(busy_cnt == 40, "R6 active cycles", busy_cnt, 40);
        if (ev_c.size() >= 2) begin
            check(ev_c[0] == 3, "R5 first code", ev_c[0], 3);
            check(ev_c[1] == 2, "R5 second code", ev_c[1], 2);
        end else check(0, "R5 codes present", ev_c.size(), 2);

        // burst longer than period: truncated, flag set R9 R2
        run(3, 12, 8, 0, 30, 16'h1234);
        check(cfg_err == 1, "R9 flag after run", cfg_err, 1);
        grid_check(3, 8, 8, 30);

        // jittered run R4 R2
        run(6, 20, 30, 7, 200, 16'hACE1);
        begin
            int off = 0;
            for (int i = 0; i < ev_t.size(); i++) begin
                check((ev_t[i] % 30) < 20, "R2 R4 jitter in window", ev_t[i] % 30, 19);
                if (i > 0) check(ev_t[i] > ev_t[i-1], "R4 order", ev_t[i], ev_t[i-1] + 1);
                if (((ev_t[i] % 30) % 6) != 0) off++;
            end
            check(off > 0, "R4 jitter moves events", off, 1);
        end
        check(cfg_err == 0, "R9 flag cleared", cfg_err, 0);

        // zero seed replaced by 1 R5
        run(5, 5, 10, 0, 25, 0);
        check(ev_c.size() == 3, "R5 zero seed events", ev_c.size(), 3);
        if (ev_c.size() > 0) check(ev_c[0] == 0, "R5 zero seed code", ev_c[0], 0);

        // stop early, start while busy ignored R8
        cfg_spacing = 2; cfg_burst = 4; cfg_period = 8; cfg_jitter_mask = 0;
        cfg_run_len = 1000; cfg_seed = 16'h5A5A;
        ev_t.delete(); busy_cnt = 0;
        start = 1; step(); start = 0;
        for (int i = 0; i < 5; i++) step();
        start = 1; step(); start = 0;
        check(int'(evt_time) == 6, "R8 start while busy ignored", evt_time, 6);
        for (int i = 0; i < 3; i++) step();
        stop = 1; step(); stop = 0;
        check(busy == 0, "R8 stop ends run", busy, 0);
        check(busy_cnt == 10, "R8 stop cycle count", busy_cnt, 10);
        step(); step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule